// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a chip's control fabric. Software programs a 32-bit period, arms the counter through a control word and must keep servicing the block. The counter steps down once for each cycle in which the tick enable input is high. On the first expiry the block raises an interrupt and starts a fresh period. If a second expiry comes while that interrupt is still pending and the reset-enable bit is set, the block drives a reset request that stays high until the block's own reset.

Stray writes cannot disarm the watchdog, because the block can be locked. While it is locked, writes to every register except the lock register are dropped. Writing the unlock key to the lock register opens the block, and writing any other value closes it again. The register bus is synchronous: word address, write strobe, write data and a combinational read-data output.

Word addresses: 0 period (read/write), 1 live count (read only), 2 control (read/write; bit 0 arms the counter, bit 1 permits reset), 3 interrupt acknowledge (write any value; reads 0), 4 lock (reads 1 when locked, 0 when open). Any other address reads 0.

Top module: `wdog_guard`

## Requirements
- R1: After reset the block is unlocked (lock reads 0), the period reads 0xFFFFFFFF, control reads 0, the count reads 0xFFFFFFFF, and irq and wdog_rst are low.
- R2: A write of UNLOCK_KEY (default 0xC0DE5AFE) to address 4 unlocks the block and a write of any other value locks it. Address 4 reads 1 while locked and 0 while unlocked.
- R3: While locked, writes to addresses 0, 2 and 3 have no effect on the period, the control word, the count or irq.
- R4: While control bit 0 is set, each cycle with tick high lowers the count by one. While bit 0 is clear, the count holds.
- R5: A write that sets control bit 0 while it is clear reloads the count from the period. The count does not resume from where it stopped.
- R6: With effective period P, the P-th tick after a reload is an expiry. If irq is low, an expiry sets irq, and every expiry loads the count with P again.
- R7: An expiry while irq is already high and control bit 1 is set drives wdog_rst high. wdog_rst then stays high until the block is reset.
- R8: An expiry while irq is already high and control bit 1 is clear only reloads the count. irq stays high and wdog_rst stays low.
- R9: A write of any value to address 3 clears irq and reloads the count from the period.
- R10: A write to address 0 loads the count with the new period at once. A period of 0 acts as 1, so the count never reads 0.
- R11: A write that reloads the count (R5, R9, R10) takes priority over a tick in the same cycle. That tick neither decrements the count nor causes an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per high cycle |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr, combinational |
| irq | output | 1 | Pending first-expiry interrupt |
| wdog_rst | output | 1 | Sticky reset request after an unserviced second expiry |

## Verification
The bench sweeps small periods, including 0 and 1, with both settings of reset-enable. This catches a design that is off by one in the expiry tick, lets the count reach 0 or fails to treat 0 as 1. It also catches a design that resets on the first expiry or ignores reset-enable. It stops and re-arms the counter to expose a design that resumes from the stopped value instead of reloading. It tries every guarded register while locked to catch a lock that lets writes through. It drives an acknowledge and a tick in the same cycle to catch a design that lets the tick win and raises a stale interrupt.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_PERIOD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_ACK    = 3'd3,
        REG_LOCK   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic period_wr;
        logic ack_wr;
        logic run_rise;
    } wr_evt_t;

    function automatic logic any_reload(input wr_evt_t e);
        return e.period_wr | e.ack_wr | e.run_rise;
    endfunction

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_AW,
    parameter int unsigned CNT_W  = WORD_W,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wdata,
    output logic              locked,
    output logic [CNT_W-1:0]  period_q,
    output ctrl_t             ctrl_q,
    output wr_evt_t           evt
);

    logic open_w;
    logic sel_period;
    logic sel_ctrl;
    logic sel_ack;
    logic sel_lock;
    ctrl_t ctrl_new;

    always_comb begin
        open_w     = !locked;
        sel_period = wr_en && (addr == ADDR_W'(REG_PERIOD));
        sel_ctrl   = wr_en && (addr == ADDR_W'(REG_CTRL));
        sel_ack    = wr_en && (addr == ADDR_W'(REG_ACK));
        sel_lock   = wr_en && (addr == ADDR_W'(REG_LOCK));
        ctrl_new   = ctrl_t'(wdata[1:0]);
        evt.period_wr = sel_period && open_w;
        evt.ack_wr    = sel_ack && open_w;
        evt.run_rise  = sel_ctrl && open_w && ctrl_new.run && !ctrl_q.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            period_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (sel_lock) begin
                locked <= (wdata != UNLOCK_KEY);
            end
            if (evt.period_wr) begin
                period_q <= wdata;
            end
            if (sel_ctrl && open_w) begin
                ctrl_q <= ctrl_new;
            end
        end
    end

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] period_q,
    input  logic [CNT_W-1:0] wdata,
    input  wr_evt_t          evt,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    logic             reload;
    logic             step;
    logic [CNT_W-1:0] reload_val;

    always_comb begin
        reload     = any_reload(evt);
        reload_val = evt.period_wr ? eff_period(wdata) : eff_period(period_q);
        step       = tick && run && !reload;
        expire     = step && (count <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (reload) begin
            count <= reload_val;
        end else if (expire) begin
            count <= eff_period(period_q);
        end else if (step) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    input  logic rst_en,
    output logic irq,
    output logic wdog_rst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            wdog_rst <= 1'b0;
        end else begin
            if (ack) begin
                irq <= 1'b0;
            end else if (expire && !irq) begin
                irq <= 1'b1;
            end
            if (expire && irq && rst_en) begin
                wdog_rst <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_AW,
    parameter int unsigned CNT_W  = WORD_W,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq,
    output logic              wdog_rst
);

    logic             locked_w;
    logic [CNT_W-1:0] period_w;
    ctrl_t            ctrl_w;
    wr_evt_t          evt_w;
    logic [CNT_W-1:0] count_w;
    logic             expire_w;

    wdg_regfile #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .locked(locked_w), .period_q(period_w), .ctrl_q(ctrl_w), .evt(evt_w)
    );

    wdg_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl_w.run),
        .period_q(period_w), .wdata(wdata), .evt(evt_w),
        .count(count_w), .expire(expire_w)
    );

    wdg_expiry u_exp (
        .clk(clk), .rst(rst), .expire(expire_w), .ack(evt_w.ack_wr),
        .rst_en(ctrl_w.rst_en), .irq(irq), .wdog_rst(wdog_rst)
    );

    always_comb begin
        if (addr == ADDR_W'(REG_PERIOD)) begin
            rdata = period_w;
        end else if (addr == ADDR_W'(REG_COUNT)) begin
            rdata = count_w;
        end else if (addr == ADDR_W'(REG_CTRL)) begin
            rdata = {{(CNT_W-2){1'b0}}, ctrl_w};
        end else if (addr == ADDR_W'(REG_LOCK)) begin
            rdata = {{(CNT_W-1){1'b0}}, locked_w};
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_AW,
    parameter int unsigned CNT_W  = WORD_W,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [CNT_W-1:0]  wdata,
    input logic              irq,
    input logic              wdog_rst,
    input logic              locked,
    input logic              run,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period
);

    assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> wdog_rst);

    assert_locked_period_R3: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && addr == ADDR_W'(REG_PERIOD)) |=> $stable(period));

    assert_lock_state_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(REG_LOCK)) |=> (locked == ($past(wdata) != UNLOCK_KEY)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(count));

    assert_irq_from_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(tick) && $past(run)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!locked && wr_en && addr == ADDR_W'(REG_ACK)) |=> !irq);

    assert_count_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        count != '0);

endmodule

bind wdog_guard wdog_guard_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .irq(irq), .wdog_rst(wdog_rst), .locked(locked_w),
    .run(ctrl_w.run), .count(count_w), .period(period_w)
);

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;

    localparam logic [31:0] KEY = 32'hC0DE_5AFE;
    localparam logic [2:0] A_PER = 3'd0, A_CNT = 3'd1, A_CTL = 3'd2,
                           A_ACK = 3'd3, A_LCK = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        wdog_rst;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    wdog_guard dut (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int e;
        do_reset();

        // R1 reset state
        rd(A_LCK, v); chk("R1 lock", v, 0);
        rd(A_PER, v); chk("R1 period", v, 32'hFFFF_FFFF);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_CNT, v); chk("R1 count", v, 32'hFFFF_FFFF);
        chk("R1 irq", irq, 0);
        chk("R1 wdog_rst", wdog_rst, 0);

        // R4 holds while disarmed
        ticks(5);
        rd(A_CNT, v); chk("R4 hold disarmed", v, 32'hFFFF_FFFF);

        // R2 and R3 lock behaviour
        wr(A_LCK, 32'h1234);
        rd(A_LCK, v); chk("R2 locked reads 1", v, 1);
        wr(A_PER, 5);
        wr(A_CTL, 3);
        wr(A_ACK, 0);
        rd(A_PER, v); chk("R3 period ignored", v, 32'hFFFF_FFFF);
        rd(A_CTL, v); chk("R3 ctrl ignored", v, 0);
        rd(A_CNT, v); chk("R3 count untouched", v, 32'hFFFF_FFFF);
        wr(A_LCK, KEY);
        rd(A_LCK, v); chk("R2 unlocked reads 0", v, 0);
        wr(A_LCK, KEY + 1);
        rd(A_LCK, v); chk("R2 near-key locks", v, 1);
        wr(A_LCK, KEY);

        // R6 R7 R8 R10 sweep over small periods and reset-enable
        for (int p = 0; p < 6; p++) begin
            for (int re = 0; re < 2; re++) begin
                do_reset();
                e = (p == 0) ? 1 : p;
                wr(A_PER, p);
                rd(A_CNT, v); chk("R10 period write reloads", v, e);
                wr(A_CTL, (re << 1) | 1);
                for (int k = 1; k < e; k++) begin
                    ticks(1);
                    rd(A_CNT, v); chk("R4 decrement", v, e - k);
                    chk("R6 no early irq", irq, 0);
                end
                ticks(1);
                chk("R6 first expiry irq", irq, 1);
                chk("R6 no reset on first", wdog_rst, 0);
                rd(A_CNT, v); chk("R6 reload after expiry", v, e);
                ticks(e);
                chk(re ? "R7 second expiry reset" : "R8 no reset", wdog_rst, re);
                chk("R8 irq stays", irq, 1);
                rd(A_CNT, v); chk("R8 reload", v, e);
                ticks(e);
                chk("R7 sticky", wdog_rst, re);
            end
        end

        // R5 rearm reloads
        do_reset();
        wr(A_PER, 10);
        wr(A_CTL, 1);
        ticks(3);
        rd(A_CNT, v); chk("R4 counted", v, 7);
        wr(A_CTL, 0);
        ticks(4);
        rd(A_CNT, v); chk("R4 stopped holds", v, 7);
        wr(A_CTL, 1);
        rd(A_CNT, v); chk("R5 rearm reloads", v, 10);

        // R9 acknowledge
        ticks(10);
        chk("R6 irq at 10", irq, 1);
        ticks(3);
        wr(A_ACK, 32'hABCD);
        chk("R9 irq cleared", irq, 0);
        rd(A_CNT, v); chk("R9 reload", v, 10);

        // R10 period write while counting
        ticks(2);
        wr(A_PER, 20);
        rd(A_CNT, v); chk("R10 immediate reload", v, 20);
        ticks(1);
        rd(A_CNT, v); chk("R10 counts from new", v, 19);

        // R11 acknowledge beats tick
        wr(A_PER, 1);
        @(negedge clk);
        tick = 1'b1;
        addr = A_ACK;
        wdata = 0;
        wr_en = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
        chk("R11 no expiry on ack cycle", irq, 0);
        rd(A_CNT, v); chk("R11 count reloaded", v, 1);
        ticks(1);
        chk("R11 next tick expires", irq, 1);

        // R3 ack and ctrl ignored while locked
        wr(A_LCK, 0);
        wr(A_ACK, 0);
        chk("R3 ack ignored", irq, 1);
        wr(A_CTL, 0);
        rd(A_CTL, v); chk("R3 ctrl kept", v, 1);
        ticks(1);
        chk("R8 locked second expiry no reset", wdog_rst, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule